// File: doc/BRIEF.md
# Block Erase and Word Program Sequencer

This block is the self-timed engine behind a flash-style memory's command logic. After a one-cycle start request it runs either a single-word program job or a whole-block erase job. It does so through a plain synchronous array port: an address, write data, a write strobe, and read data that comes back one clock after the address. It steps word by word across the selected block, checks every write by reading it back, and repeats a write pulse when the readback does not match. When the job ends it raises a one-cycle done pulse together with a pass flag and separate program-error and erase-error flags.

A program job can only clear bits. The sequencer first reads the old word and writes the old word ANDed with the requested data, then verifies against that merged value. An erase job always has four passes in a fixed order: drive every word of the block to all zeros, verify all zeros, drive every word to all ones, and verify all ones. Only the block captured at start is touched, and it stays fixed until the job ends.

Top module: `blk_pe_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o, done_o, arr_we_o, pass_o, perr_o and eerr_o are all 0.
- R2: A start_i sampled while busy_o is 0 raises busy_o in the next cycle. busy_o then stays high until the cycle in which done_o is 1. In that cycle busy_o is 0, and done_o lasts exactly one cycle. A start_i sampled while busy_o is 1 is ignored.
- R3: A program job (op_i = 0) leaves the chosen word equal to its old value ANDed with data_i and reports pass_o = 1.
- R4: Programming a 1 over a stored 0 leaves that bit at 0 and reports no error: with data_i all ones the word is unchanged and pass_o = 1.
- R5: An erase job (op_i = 1) leaves every word of the selected block at all ones with pass_o = 1, and words in other blocks are unchanged.
- R6: During an erase, every word of the block is written and verified as all zeros before the first all-ones write. After the first all-ones write, no word of that job is written with zeros.
- R7: Every array write falls inside the block given at start (address bits above the word offset). A program job writes only the word given at start.
- R8: Each word gets at most 8 write pulses in one verify phase. A word that takes effect on its 8th pulse passes.
- R9: A program word that still mismatches after 8 pulses ends the job with pass_o = 0, perr_o = 1, eerr_o = 0.
- R10: An erase word that mismatches after 8 pulses in either verify phase ends the job with pass_o = 0, eerr_o = 1, perr_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle job request, taken only when idle |
| op_i | input | 1 | Job kind: 0 program word, 1 erase block |
| blk_i | input | BLK_W | Block number for the job |
| word_i | input | OFF_W | Word offset inside the block (program only) |
| data_i | input | WORD_W | Data to program (program only) |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle job completion pulse |
| pass_o | output | 1 | Job succeeded; held until next start |
| perr_o | output | 1 | Program verify failure; held until next start |
| eerr_o | output | 1 | Erase verify failure; held until next start |
| arr_addr_o | output | BLK_W+OFF_W | Array word address {block, offset} |
| arr_wdata_o | output | WORD_W | Array write data |
| arr_we_o | output | 1 | Array write strobe |
| arr_rdata_i | input | WORD_W | Array read data, valid one cycle after the address |

## Verification
The assertions assume that the array returns, one clock after an address, the word stored there, and that start_i is a single-cycle pulse. They also assume that the block count is at least two, so that the block bits of the address exist. The bench keeps to this with a behavioural array that registers its read data and applies writes at the clock edge. It drives start only as one-cycle pulses from tasks, and its slow cells delay or swallow write pulses but never corrupt reads. The one start request sent during a busy job is still a single pulse, and it goes to a different block so that any wrongful acceptance would show up.

// File: rtl/blkseq_pkg.sv
package blkseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_LWAIT = 3'd2,
    ST_WPASS = 3'd3,
    ST_VRD   = 3'd4,
    ST_VCMP  = 3'd5,
    ST_VWR   = 3'd6
  } seq_state_t;

  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } seq_op_t;

endpackage

// File: rtl/blkseq_walk.sv
module blkseq_walk #(
  parameter int WORDS = 16,
  localparam int OFF_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OFF_W-1:0] load_val,
  input  logic             step,
  output logic [OFF_W-1:0] off_o,
  output logic             last_o
);

  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q <= '0;
    end else if (load) begin
      off_q <= load_val;
    end else if (step) begin
      off_q <= (off_q == LAST_OFF) ? '0 : off_q + 1'b1;
    end
  end

  assign off_o  = off_q;
  assign last_o = (off_q == LAST_OFF);

  // R7: the word pointer never leaves the block
  assert_off_range_R7: assert property (@(posedge clk) disable iff (rst)
    off_q <= LAST_OFF);

endmodule

// File: rtl/blkseq_retry.sv
module blkseq_retry #(
  parameter int MAX_TRIES = 8,
  localparam int TRY_W = $clog2(MAX_TRIES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_max_o
);

  localparam logic [TRY_W-1:0] LIMIT = TRY_W'(MAX_TRIES);

  logic [TRY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= TRY_W'(1);
    end else if (clr) begin
      cnt_q <= TRY_W'(1);
    end else if (inc && (cnt_q != LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign at_max_o = (cnt_q == LIMIT);

  // R8: a pulse is never requested past the attempt limit
  assert_try_bound_R8: assert property (@(posedge clk) disable iff (rst)
    at_max_o |-> !inc);

endmodule

// File: rtl/blkseq_cmp.sv
module blkseq_cmp #(
  parameter int WORD_W = 16,
  parameter int LANE_W = 8,
  localparam int NLANE = WORD_W / LANE_W
) (
  input  logic [WORD_W-1:0] rd_i,
  input  logic [WORD_W-1:0] tgt_i,
  input  logic [WORD_W-1:0] old_i,
  input  logic [WORD_W-1:0] new_i,
  output logic              match_o,
  output logic [WORD_W-1:0] merged_o
);

  logic [NLANE-1:0] lane_eq;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign lane_eq[l] = (rd_i[l*LANE_W +: LANE_W] == tgt_i[l*LANE_W +: LANE_W]);
    assign merged_o[l*LANE_W +: LANE_W] =
      old_i[l*LANE_W +: LANE_W] & new_i[l*LANE_W +: LANE_W];
  end

  if (NLANE * LANE_W < WORD_W) begin : g_tail
    localparam int TB = NLANE * LANE_W;
    assign merged_o[WORD_W-1:TB] = old_i[WORD_W-1:TB] & new_i[WORD_W-1:TB];
    assign match_o = (&lane_eq) && (rd_i[WORD_W-1:TB] == tgt_i[WORD_W-1:TB]);
  end else begin : g_full
    assign match_o = &lane_eq;
  end

endmodule

// File: rtl/blk_pe_seq.sv
module blk_pe_seq
  import blkseq_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int BLK_WORDS = 16,
  parameter int NUM_BLKS  = 4,
  parameter int MAX_TRIES = 8,
  parameter int LANE_W    = 8,
  localparam int OFF_W  = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1,
  localparam int BLK_W  = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1,
  localparam int ADDR_W = BLK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              op_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [OFF_W-1:0]  word_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              perr_o,
  output logic              eerr_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [WORD_W-1:0] arr_wdata_o,
  output logic              arr_we_o,
  input  logic [WORD_W-1:0] arr_rdata_i
);

  seq_state_t        state_q, state_n;
  seq_op_t           op_q;
  logic [BLK_W-1:0]  blk_q;
  logic [WORD_W-1:0] data_q;
  logic [WORD_W-1:0] tgt_q;
  logic              phase_q;
  logic              busy_q, done_q, pass_q, perr_q, eerr_q, we_q;

  logic              walk_load, walk_step;
  logic [OFF_W-1:0]  walk_val;
  logic [OFF_W-1:0]  off;
  logic              last;
  logic              try_clr, try_inc, at_max;
  logic              match;
  logic [WORD_W-1:0] merged;
  logic              accept, phase_adv, finish, fail;

  blkseq_walk #(.WORDS(BLK_WORDS)) u_walk (
    .clk(clk), .rst(rst), .load(walk_load), .load_val(walk_val),
    .step(walk_step), .off_o(off), .last_o(last)
  );

  blkseq_retry #(.MAX_TRIES(MAX_TRIES)) u_retry (
    .clk(clk), .rst(rst), .clr(try_clr), .inc(try_inc), .at_max_o(at_max)
  );

  blkseq_cmp #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_cmp (
    .rd_i(arr_rdata_i), .tgt_i(tgt_q), .old_i(arr_rdata_i), .new_i(data_q),
    .match_o(match), .merged_o(merged)
  );

  always_comb begin
    state_n   = state_q;
    walk_load = 1'b0;
    walk_val  = '0;
    walk_step = 1'b0;
    try_clr   = 1'b0;
    try_inc   = 1'b0;
    accept    = 1'b0;
    phase_adv = 1'b0;
    finish    = 1'b0;
    fail      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept    = 1'b1;
          walk_load = 1'b1;
          try_clr   = 1'b1;
          if (seq_op_t'(op_i) == OP_ERASE) begin
            walk_val = '0;
            state_n  = ST_WPASS;
          end else begin
            walk_val = word_i;
            state_n  = ST_LOAD;
          end
        end
      end
      ST_LOAD:  state_n = ST_LWAIT;
      ST_LWAIT: state_n = ST_WPASS;
      ST_WPASS: begin
        if (op_q == OP_PROG) begin
          state_n = ST_VRD;
        end else if (last) begin
          walk_load = 1'b1;
          state_n   = ST_VRD;
        end else begin
          walk_step = 1'b1;
        end
      end
      ST_VRD: state_n = ST_VCMP;
      ST_VCMP: begin
        if (match) begin
          if ((op_q == OP_ERASE) && !last) begin
            walk_step = 1'b1;
            try_clr   = 1'b1;
            state_n   = ST_VRD;
          end else if ((op_q == OP_ERASE) && !phase_q) begin
            walk_load = 1'b1;
            try_clr   = 1'b1;
            phase_adv = 1'b1;
            state_n   = ST_WPASS;
          end else begin
            finish  = 1'b1;
            state_n = ST_IDLE;
          end
        end else if (at_max) begin
          finish  = 1'b1;
          fail    = 1'b1;
          state_n = ST_IDLE;
        end else begin
          try_inc = 1'b1;
          state_n = ST_VWR;
        end
      end
      ST_VWR:  state_n = ST_VRD;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_q    <= OP_PROG;
      blk_q   <= '0;
      data_q  <= '0;
      tgt_q   <= '0;
      phase_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      perr_q  <= 1'b0;
      eerr_q  <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      busy_q  <= (state_n != ST_IDLE);
      we_q    <= (state_n == ST_WPASS) || (state_n == ST_VWR);
      done_q  <= finish;
      if (accept) begin
        op_q    <= seq_op_t'(op_i);
        blk_q   <= blk_i;
        data_q  <= data_i;
        phase_q <= 1'b0;
        tgt_q   <= '0;
        pass_q  <= 1'b0;
        perr_q  <= 1'b0;
        eerr_q  <= 1'b0;
      end
      if (state_q == ST_LWAIT) begin
        tgt_q <= merged;
      end
      if (phase_adv) begin
        phase_q <= 1'b1;
        tgt_q   <= '1;
      end
      if (finish) begin
        pass_q <= !fail;
        perr_q <= fail && (op_q == OP_PROG);
        eerr_q <= fail && (op_q == OP_ERASE);
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign pass_o      = pass_q;
  assign perr_o      = perr_q;
  assign eerr_o      = eerr_q;
  assign arr_we_o    = we_q;
  assign arr_addr_o  = {blk_q, off};
  assign arr_wdata_o = tgt_q;

  // R2: done is a single-cycle pulse
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R2: done arrives as busy drops, ending a busy stretch
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  // R7: the array is written only during a job
  assert_we_busy_R7: assert property (@(posedge clk) disable iff (rst)
    arr_we_o |-> busy_o);

  // R7: block address bits hold for the whole job
  assert_blk_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(arr_addr_o[ADDR_W-1 -: BLK_W]));

  // R9, R10: exactly one result flag accompanies done
  assert_result_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($countones({pass_o, perr_o, eerr_o}) == 1));

  // R10: an erase failure never shows up as a program failure
  assert_err_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({perr_o, eerr_o}));

endmodule

// File: tb/test_blk_pe_seq.sv
module test_blk_pe_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 16;
  localparam int BLK_WORDS = 16;
  localparam int NUM_BLKS = 4;
  localparam int OFF_W = 4;
  localparam int BLK_W = 2;
  localparam int ADDR_W = 6;
  localparam int TOTAL = BLK_WORDS * NUM_BLKS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic op = 1'b0;
  logic [BLK_W-1:0] blk = '0;
  logic [OFF_W-1:0] word = '0;
  logic [WORD_W-1:0] data = '0;
  logic busy_o, done_o, pass_o, perr_o, eerr_o, arr_we_o;
  logic [ADDR_W-1:0] arr_addr_o;
  logic [WORD_W-1:0] arr_wdata_o;
  logic [WORD_W-1:0] arr_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_pe_seq i_blk_pe_seq (
    .clk(clk), .rst(rst), .start_i(start), .op_i(op), .blk_i(blk),
    .word_i(word), .data_i(data), .busy_o(busy_o), .done_o(done_o),
    .pass_o(pass_o), .perr_o(perr_o), .eerr_o(eerr_o),
    .arr_addr_o(arr_addr_o), .arr_wdata_o(arr_wdata_o),
    .arr_we_o(arr_we_o), .arr_rdata_i(arr_rdata)
  );

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  logic [WORD_W-1:0] mem [TOTAL];
  logic [WORD_W-1:0] snap [TOTAL];
  int weak_addr = -1;
  int weak_need = 0;
  int weak_cnt = 0;
  int job_op = 0, job_blk = 0, job_word = 0;
  bit ones_seen = 0;
  int zero_wr = 0, one_wr = 0;
  bit st_s = 0, bsy_s = 0, rst_s = 1;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // behavioural array with one slow/stuck cell
  always @(posedge clk) begin
    if (arr_we_o) begin
      int a, b, w;
      a = int'(arr_addr_o);
      b = a / BLK_WORDS;
      w = a % BLK_WORDS;
      chk(b == job_blk, "R7 write block", b, job_blk);
      if (job_op == 0) chk(w == job_word, "R7 program word", w, job_word);
      if (job_op == 1) begin
        if (arr_wdata_o == '1) begin
          one_wr++;
          if (!ones_seen) begin
            bit allz = 1;
            ones_seen = 1;
            for (int i = 0; i < BLK_WORDS; i++)
              if (mem[job_blk*BLK_WORDS+i] != '0) allz = 0;
            chk(allz, "R6 zeros before ones", allz, 1);
          end
        end else begin
          zero_wr++;
          chk(!ones_seen && arr_wdata_o == '0, "R6 zero write order",
              arr_wdata_o, 0);
        end
      end
      if (a == weak_addr) begin
        weak_cnt++;
        if (weak_cnt >= weak_need) mem[a] <= arr_wdata_o;
      end else begin
        mem[a] <= arr_wdata_o;
      end
    end
    arr_rdata <= mem[arr_addr_o];
  end

  // per-clock busy/done reference
  always @(posedge clk) begin
    st_s  <= start && !busy_o;
    bsy_s <= busy_o;
    rst_s <= rst;
    cycles++;
    if (cycles > 150000) begin
      chk(0, "watchdog", cycles, 150000);
      report();
    end
  end

  always @(negedge clk) begin
    bit exp;
    exp = rst_s ? 1'b0 : (st_s ? 1'b1 : (bsy_s && !done_o));
    chk(busy_o == exp, "R2 busy per clock", busy_o, exp);
    if (done_o) begin
      chk(bsy_s && !rst_s, "R2 done after busy", bsy_s, 1);
      done_flag = 1;
    end
  end

  task automatic take_snap();
    for (int i = 0; i < TOTAL; i++) snap[i] = mem[i];
  endtask

  task automatic set_weak(input int a, input int need);
    weak_addr = a;
    weak_need = need;
    weak_cnt = 0;
  endtask

  task automatic run_job(input int o, input int b, input int w,
                         input logic [WORD_W-1:0] d, input bit inject);
    int t;
    job_op = o; job_blk = b; job_word = w;
    ones_seen = 0; zero_wr = 0; one_wr = 0;
    @(negedge clk);
    done_flag = 0;
    start = 1'b1; op = o[0]; blk = b[BLK_W-1:0]; word = w[OFF_W-1:0]; data = d;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      repeat (5) @(negedge clk);
      start = 1'b1; op = 1'b0; blk = 2'd3; word = 4'd1; data = 16'h0000;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done_flag && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(done_flag, "R2 done seen", done_flag, 1);
    @(negedge clk);
    chk(!done_o, "R2 done one cycle", done_o, 0);
  endtask

  initial begin
    for (int i = 0; i < TOTAL; i++) mem[i] = WORD_W'((i * 16'h1357) ^ 16'hA5C3);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy_o, done_o, arr_we_o, pass_o, perr_o, eerr_o} == 6'b0,
        "R1 reset outputs", {busy_o, done_o, arr_we_o, pass_o, perr_o, eerr_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({busy_o, done_o, arr_we_o} == 3'b0, "R1 after reset",
        {busy_o, done_o, arr_we_o}, 0);

    // R3: AND merge
    mem[1*16+3] = 16'hFF00;
    take_snap();
    run_job(0, 1, 3, 16'hF0F0, 0);
    chk(mem[1*16+3] == 16'hF000, "R3 merged word", mem[1*16+3], 16'hF000);
    chk(mem[1*16+4] == snap[1*16+4], "R7 neighbour word", mem[1*16+4], snap[1*16+4]);
    chk(pass_o && !perr_o && !eerr_o, "R3 pass", {pass_o, perr_o, eerr_o}, 3'b100);

    // R4: ones do not set cleared bits
    mem[0*16+5] = 16'h1234;
    run_job(0, 0, 5, 16'hFFFF, 0);
    chk(mem[5] == 16'h1234, "R4 word unchanged", mem[5], 16'h1234);
    chk(pass_o && !perr_o, "R4 no error", {pass_o, perr_o}, 2'b10);

    // R5/R6: erase block 2
    take_snap();
    run_job(1, 2, 0, 16'h0, 0);
    begin
      bit ok5 = 1, oth = 1;
      for (int i = 0; i < TOTAL; i++) begin
        if (i / BLK_WORDS == 2) begin
          if (mem[i] != 16'hFFFF) ok5 = 0;
        end else if (mem[i] != snap[i]) oth = 0;
      end
      chk(ok5, "R5 block all ones", ok5, 1);
      chk(oth, "R5 other blocks kept", oth, 1);
    end
    chk(pass_o && !eerr_o, "R5 erase pass", {pass_o, eerr_o}, 2'b10);
    chk(zero_wr == BLK_WORDS, "R6 zero writes", zero_wr, BLK_WORDS);
    chk(one_wr == BLK_WORDS, "R6 one writes", one_wr, BLK_WORDS);

    // R8: cell taking effect on the 8th pulse
    mem[3*16+7] = 16'hFFFF;
    set_weak(3*16+7, 8);
    run_job(0, 3, 7, 16'h00FF, 0);
    chk(mem[3*16+7] == 16'h00FF, "R8 slow cell written", mem[3*16+7], 16'h00FF);
    chk(pass_o, "R8 slow cell pass", pass_o, 1);
    chk(weak_cnt == 8, "R8 pulse count", weak_cnt, 8);

    // R9: cell needing 9 pulses fails a program
    mem[3*16+9] = 16'hFFFF;
    set_weak(3*16+9, 9);
    run_job(0, 3, 9, 16'h0F0F, 0);
    chk(!pass_o && perr_o && !eerr_o, "R9 program error",
        {pass_o, perr_o, eerr_o}, 3'b010);
    chk(weak_cnt == 8, "R9 pulse limit", weak_cnt, 8);
    chk(mem[3*16+9] == 16'hFFFF, "R9 cell kept", mem[3*16+9], 16'hFFFF);

    // R10: stuck cell fails an erase
    mem[0*16+2] = 16'h5555;
    set_weak(0*16+2, 1000);
    run_job(1, 0, 0, 16'h0, 0);
    chk(!pass_o && eerr_o && !perr_o, "R10 erase error",
        {pass_o, perr_o, eerr_o}, 3'b001);
    chk(weak_cnt == 8, "R10 pulse limit", weak_cnt, 8);
    chk(one_wr == 0, "R6 no ones after failed zero verify", one_wr, 0);

    // R2: start during busy is ignored
    set_weak(-1, 0);
    take_snap();
    run_job(1, 1, 0, 16'h0, 1);
    begin
      bit k3 = 1, k1 = 1;
      for (int i = 0; i < BLK_WORDS; i++) begin
        if (mem[3*16+i] != snap[3*16+i]) k3 = 0;
        if (mem[1*16+i] != 16'hFFFF) k1 = 0;
      end
      chk(k3, "R2 ignored start left block 3", k3, 1);
      chk(k1 && pass_o, "R5 erase with ignored start", {k1, pass_o}, 2'b11);
    end

    // R3 boundary words after erase
    run_job(0, 1, 0, 16'h0000, 0);
    chk(mem[16] == 16'h0000, "R3 first word", mem[16], 16'h0000);
    run_job(0, 1, 15, 16'h8001, 0);
    chk(mem[31] == 16'h8001 && pass_o, "R3 last word", mem[31], 16'h8001);

    repeat (3) @(negedge clk);
    report();
  end

endmodule